// File: doc/BRIEF.md
# Color STN Pixel Byte Packer

This block sits between a pixel source that emits one 3-bit color pixel per transfer (one bit each for red, green and blue) and the 8-bit data bus of a passive color STN panel. Eight pixels make 24 bits, so each output byte holds two and two-thirds pixels. The block packs every eight-pixel group into three bytes, and the bytes cross pixel boundaries in a fixed pattern.

Each color channel has its own 3-bit shift-left register, and all three registers shift in the same cycle. When the pixel that completes a byte is accepted, the byte is built in the next cycle. A position multiplexer reads the three channel registers plus one carried bit and writes the result into a 3-byte output FIFO. A frame-start pulse realigns packing so that a new group begins at every frame.

Both data edges use valid/ready handshakes. A transfer happens in a cycle where valid and ready are both high. On the output side, a byte that is offered stays on the bus unchanged until it is taken. On the input side, ready drops only when the offered pixel would complete a byte and the FIFO has no room for it. In that case the source must hold the pixel. Ready never depends on the output-side ready in the same cycle.

Top module: `stn_pix_packer`

## Requirements
- R1: An input pixel uses bit 0 for red, bit 1 for green and bit 2 for blue. Pixels P0..P7 of a group form a 24-bit stream, with P0 red at stream bit 0 and the bits running R, G, B per pixel. The first byte of a group is stream bits 7..0: bit 0 = P0 red, bit 7 = P2 green.
- R2: The second byte of a group is stream bits 15..8: bit 0 = P2 blue, bits 1..3 = P3 R/G/B, bits 4..6 = P4 R/G/B, bit 7 = P5 red.
- R3: The third byte of a group is stream bits 23..16: bit 0 = P5 green, bit 1 = P5 blue, bits 2..4 = P6 R/G/B, bits 5..7 = P7 R/G/B. The pixel accepted next is P0 of a new group.
- R4: A completed byte joins the output FIFO at the clock edge after the edge that accepted its last pixel. Bytes leave in the order they were completed, and byte_valid is high exactly when the FIFO is not empty.
- R5: While byte_valid is high and byte_ready is low, byte_valid stays high and byte_data stays unchanged.
- R6: pix_ready is low only when the offered pixel would complete a byte and the FIFO bytes plus any byte awaiting entry already equal the FIFO depth. No accepted pixel or completed byte is ever lost.
- R7: When frame_start is high, a pixel accepted in that cycle (or, if none, the next pixel accepted) becomes P0 of a new group. Partially packed bits are discarded. Completed bytes already in the FIFO, or awaiting entry, are kept. pix_ready is high whenever frame_start is high.
- R8: After reset the FIFO is empty, byte_valid is low, pix_ready is high and the next pixel is P0.
- R9: The FIFO holds exactly three bytes. With the sink stalled and the packer aligned at P0, exactly ten pixels are accepted: one full group plus the two pixels that do not complete a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Realign packing to a new group (plain control) |
| pix_valid | input | 1 | Input pixel offered |
| pix_ready | output | 1 | Input pixel can be taken |
| pix_rgb | input | 3 | Pixel bits: 0 red, 1 green, 2 blue |
| byte_valid | output | 1 | Output byte offered |
| byte_ready | input | 1 | Sink takes the byte |
| byte_data | output | 8 | Packed panel byte |

## Verification
The bench builds the block with its default values: a FIFO depth of three bytes and 3-bit channel registers. At this depth a stalled sink fills the FIFO within one eight-pixel group, so the input stall, the two still-accepted pixels and the release all fall inside a short directed run. The depth also keeps the conservative ready rule in play during random traffic, which mixes sink back-pressure with frame-start pulses. Frame-start pulses land in every slot of a group, including the cycle where a completed byte is still waiting to enter the FIFO.

// File: rtl/stn_pack_pkg.sv
package stn_pack_pkg;

  localparam int CHANNELS   = 3;
  localparam int BYTE_W     = 8;
  localparam int GROUP_PIX  = 8;
  localparam int SLOT_W     = $clog2(GROUP_PIX);

  typedef logic [CHANNELS-1:0] rgb_t;
  typedef logic [BYTE_W-1:0]   byte_t;
  typedef logic [SLOT_W-1:0]   slot_t;

  // which byte of the group a completing pixel closes
  typedef enum logic [1:0] {
    KIND_FIRST  = 2'd0,
    KIND_SECOND = 2'd1,
    KIND_THIRD  = 2'd2
  } byte_kind_e;

  // slots whose pixel finishes a byte: 2 (bits 7..0), 5 (15..8), 7 (23..16)
  function automatic logic slot_closes_byte(input slot_t s);
    return (s == slot_t'(2)) || (s == slot_t'(5)) || (s == slot_t'(GROUP_PIX - 1));
  endfunction

  function automatic byte_kind_e slot_kind(input slot_t s);
    byte_kind_e k;
    if (s == slot_t'(2))      k = KIND_FIRST;
    else if (s == slot_t'(5)) k = KIND_SECOND;
    else                      k = KIND_THIRD;
    return k;
  endfunction

endpackage

// File: rtl/stn_chan_shift.sv
module stn_chan_shift #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [DEPTH-1:0] taps
);

  // newest bit enters at index 0; oldest sits at DEPTH-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (clr) begin
      taps <= shift_en ? {{(DEPTH-1){1'b0}}, bit_in} : '0;
    end else if (shift_en) begin
      taps <= {taps[DEPTH-2:0], bit_in};
    end
  end

endmodule

// File: rtl/stn_byte_mux.sv
module stn_byte_mux
  import stn_pack_pkg::*;
(
  input  logic [2:0]  red_t,
  input  logic [2:0]  grn_t,
  input  logic [2:0]  blu_t,
  input  logic        carry_in,
  input  byte_kind_e  kind,
  output byte_t       byte_o,
  output logic        carry_out,
  output logic        carry_we
);

  // taps[2] = oldest of the last three pixels, taps[0] = newest
  always_comb begin
    byte_o    = '0;
    carry_out = 1'b0;
    carry_we  = 1'b0;
    unique case (kind)
      KIND_FIRST: begin
        // regs hold P0, P1, P2
        byte_o    = {grn_t[0], red_t[0],
                     blu_t[1], grn_t[1], red_t[1],
                     blu_t[2], grn_t[2], red_t[2]};
        carry_out = blu_t[0];
        carry_we  = 1'b1;
      end
      KIND_SECOND: begin
        // regs hold P3, P4, P5; P2 blue arrives via the carry
        byte_o = {red_t[0],
                  blu_t[1], grn_t[1], red_t[1],
                  blu_t[2], grn_t[2], red_t[2],
                  carry_in};
      end
      default: begin
        // regs hold P5, P6, P7
        byte_o = {blu_t[0], grn_t[0], red_t[0],
                  blu_t[1], grn_t[1], red_t[1],
                  blu_t[2], grn_t[2]};
      end
    endcase
  end

endmodule

// File: rtl/stn_byte_fifo.sv
module stn_byte_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (cnt != '0);
  assign pop       = out_valid && out_ready;
  assign dout      = mem[rp];
  assign level     = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  // R6: the packer never writes into a full FIFO
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)))
    else $error("FIFO written while full");

  // R5: an offered byte is held until taken
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)))
    else $error("offered byte changed before handshake");

  // R8: reset empties the FIFO
  p_reset_empty_r8: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0))
    else $error("FIFO not empty after reset");

endmodule

// File: rtl/stn_pix_packer.sv
module stn_pix_packer
  import stn_pack_pkg::*;
#(
  parameter int FIFO_DEPTH = 3,
  parameter int CHAN_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       pix_valid,
  output logic       pix_ready,
  input  logic [2:0] pix_rgb,
  output logic       byte_valid,
  input  logic       byte_ready,
  output logic [7:0] byte_data
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  slot_t            slot_q, slot_eff;
  logic             closes, accept;
  logic             pend_q;
  byte_kind_e       pend_kind_q;
  logic             carry_q;
  logic [CW-1:0]    fifo_level;
  logic [CW:0]      occupancy;
  logic [CHAN_DEPTH-1:0] taps [CHANNELS];
  byte_t            built;
  logic             carry_nxt, carry_we;

  // a frame start makes the offered pixel slot 0
  assign slot_eff  = frame_start ? '0 : slot_q;
  assign closes    = slot_closes_byte(slot_eff);
  assign occupancy = {1'b0, fifo_level} + {{CW{1'b0}}, pend_q};
  assign pix_ready = !closes || (occupancy < (CW+1)'(FIFO_DEPTH));
  assign accept    = pix_valid && pix_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q      <= '0;
      pend_q      <= 1'b0;
      pend_kind_q <= KIND_FIRST;
    end else begin
      if (accept)
        slot_q <= (slot_eff == slot_t'(GROUP_PIX - 1)) ? '0 : slot_eff + 1'b1;
      else if (frame_start)
        slot_q <= '0;
      pend_q      <= accept && closes;
      pend_kind_q <= slot_kind(slot_eff);
    end
  end

  // carried P2 blue between first and second byte of a group
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  carry_q <= 1'b0;
    else if (frame_start)        carry_q <= 1'b0;
    else if (pend_q && carry_we) carry_q <= carry_nxt;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    stn_chan_shift #(.DEPTH(CHAN_DEPTH)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frame_start),
      .shift_en (accept),
      .bit_in   (pix_rgb[c]),
      .taps     (taps[c])
    );
  end

  stn_byte_mux u_mux (
    .red_t     (taps[0][2:0]),
    .grn_t     (taps[1][2:0]),
    .blu_t     (taps[2][2:0]),
    .carry_in  (carry_q),
    .kind      (pend_kind_q),
    .byte_o    (built),
    .carry_out (carry_nxt),
    .carry_we  (carry_we)
  );

  stn_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pend_q),
    .din       (built),
    .out_ready (byte_ready),
    .out_valid (byte_valid),
    .dout      (byte_data),
    .level     (fifo_level)
  );

  // R4: a closing pixel shows up as an offered byte two edges later
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && closes) |-> ##2 byte_valid)
    else $error("completed byte not offered in time");

  // R7: a frame start never stalls the source
  p_frame_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> pix_ready)
    else $error("input stalled on frame start");

endmodule

// File: tb/sim_stn_pix_packer.sv
module sim_stn_pix_packer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [2:0] pix_rgb = '0;
  logic       byte_valid;
  logic       byte_ready = 1'b0;
  logic [7:0] byte_data;

  always #2.5 clk = ~clk;

  stn_pix_packer u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_rgb(pix_rgb),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int cyc    = 0;

  // behavioural model state
  logic [7:0] mq[$];
  int         mi[$];
  int         acc = 0;
  int         nb = 0;
  int         bidx = 0;
  bit         pend_m = 0;
  logic [7:0] pend_b;
  int         pend_i;
  string      tag_over = "";
  bit         prev_stall = 0;
  logic [7:0] prev_data;
  int         accepted = 0;
  logic [31:0] lfsr = 32'h1ace_b00c;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic step(input bit v, input logic [2:0] rgb, input bit fs, input bit rdy);
    bit    compl, exp_rdy, fire_in, fire_out;
    string dtag;
    @(negedge clk);
    pix_valid = v; pix_rgb = rgb; frame_start = fs; byte_ready = rdy;
    #1;
    // R4: valid mirrors model FIFO occupancy
    chk(byte_valid === (mq.size() != 0), "R4", byte_valid, mq.size() != 0);
    if (byte_valid && mq.size() != 0) begin
      dtag = (mi[0] == 0) ? "R1" : (mi[0] == 1) ? "R2" : "R3";
      if (tag_over != "") dtag = tag_over;
      chk(byte_data === mq[0], dtag, byte_data, mq[0]);
    end
    // R5: held byte stays put
    if (prev_stall)
      chk(byte_valid && (byte_data === prev_data), "R5", byte_data, prev_data);
    // R6 / R7: ready rule
    compl   = (((fs ? 0 : nb) + 3) >= 8);
    exp_rdy = !compl || ((mq.size() + pend_m) < 3);
    chk(pix_ready === exp_rdy, fs ? "R7" : "R6", pix_ready, exp_rdy);
    fire_in  = v && pix_ready;
    fire_out = byte_valid && rdy;
    prev_stall = byte_valid && !rdy;
    prev_data  = byte_data;
    // model update for the coming edge
    if (fire_out && mq.size() != 0) begin
      void'(mq.pop_front());
      void'(mi.pop_front());
    end
    if (pend_m) begin
      mq.push_back(pend_b);
      mi.push_back(pend_i);
      pend_m = 0;
    end
    if (fs) begin
      acc = 0; nb = 0; bidx = 0;
    end
    if (fire_in) begin
      accepted++;
      acc = acc | (int'(rgb) << nb);
      nb  = nb + 3;
      if (nb >= 8) begin
        pend_b = acc[7:0];
        pend_i = bidx;
        bidx   = (bidx + 1) % 3;
        acc    = acc >> 8;
        nb     = nb - 8;
        pend_m = 1;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(byte_valid === 1'b0, "R8", byte_valid, 0);
    chk(pix_ready === 1'b1, "R8", pix_ready, 1);
    rst_n = 1'b1;

    // R1 R2 R3: walking patterns, sink always ready
    for (int i = 0; i < 48; i++) step(1, 3'(i % 8), 0, 1);
    for (int i = 0; i < 48; i++) step(1, 3'((i * 5 + 3) % 8), 0, 1);
    for (int i = 0; i < 24; i++) step(1, (i % 3 == 0) ? 3'b001 : 3'b110, 0, 1);
    for (int i = 0; i < 8; i++) step(0, 3'b0, 0, 1);

    // R9: stall from aligned start; ten pixels must enter
    accepted = 0;
    step(1, 3'b101, 1, 0);
    for (int i = 1; i < 14; i++) step(1, 3'(i % 8), 0, 0);
    chk(accepted == 10, "R9", accepted, 10);
    for (int i = 0; i < 16; i++) step(1, 3'(i % 8), 0, 1);
    for (int i = 0; i < 8; i++) step(0, 3'b0, 0, 1);

    // R7: frame starts at several slots
    tag_over = "R7";
    step(1, 3'b111, 1, 1);
    for (int i = 0; i < 4; i++) step(1, 3'(i + 1), 0, 1);
    step(1, 3'b010, 1, 1);
    for (int i = 0; i < 10; i++) step(1, 3'(7 - i % 8), 0, 1);
    step(0, 3'b000, 1, 1);
    for (int i = 0; i < 8; i++) step(1, 3'(i), 0, 1);
    for (int i = 0; i < 2; i++) step(1, 3'b100, 0, 1);
    step(1, 3'b011, 1, 0);
    for (int i = 0; i < 12; i++) step(1, 3'(i % 8), 0, 1);
    for (int i = 0; i < 8; i++) step(0, 3'b0, 0, 1);
    tag_over = "";

    // random traffic with back-pressure and rare frame starts
    for (int i = 0; i < 4000; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[0] | lfsr[1], lfsr[4:2], (lfsr[12:8] == 5'd0), lfsr[5] | lfsr[6]);
    end
    for (int i = 0; i < 12; i++) step(0, 3'b0, 0, 1);
    chk(byte_valid === 1'b0, "R4", byte_valid, 0);
    finish_run();
  end

endmodule